// File: doc/BRIEF.md
# Cascaded Receiver Symbol Claim Chain

A per-receiver control stage that lets several identical receivers listen to one serial link and split a message between them. The stage takes decoded symbols, each marked as Sync or data by a valid strobe and a Sync flag. It also takes a catch-next input from its upstream neighbour. It drives a got-mine output to its downstream neighbour, a holding register, and an output latch with a one-cycle strobe.

Receivers are daisy-chained. The catch-next input of the first stage is tied high, and each got-mine output feeds the catch-next input of the next stage. The first stage takes the first data symbol of a message and raises got-mine. The second stage then takes the following symbol, and so on down the chain. When the closing Sync arrives, every stage that holds a symbol releases it on the same clock.

The controller has three states:
- **OPEN**: unclaimed. The transition *claim* (a valid data symbol while catch-next is high) moves to HELD and loads the holding register.
- **HELD**: one symbol is held and got-mine is driven. The transition *sync_release* (a valid Sync) returns to OPEN and loads the output latch. The transition *drop_release* (catch-next low, with no Sync and no half-Sync in that cycle) moves to SPENT and loads the output latch.
- **SPENT**: released early, with no claim allowed. The transition *rearm* (a valid Sync) returns to OPEN without a strobe.

Top module: `symclaim_stage`

## Requirements
- R1: After reset, got_mine is 0, out_stb is 0 and out_data is 0.
- R2: In OPEN, a cycle with sym_valid=1, sym_is_sync=0 and catch_next=1 loads sym_data into the holding register. got_mine is then 1 from the next cycle on, for as long as catch_next stays 1 and no Sync or half-Sync is present.
- R3: got_mine is 0 in any cycle where sym_half_sync=1, where sym_valid=1 with sym_is_sync=1, or where catch_next=0.
- R4: A valid Sync in HELD makes out_data equal the held symbol, with out_stb=1 for exactly one cycle, on the clock edge that samples the Sync. All holding stages in a chain strobe in the same cycle.
- R5: In HELD, catch_next=0 with no Sync and no half-Sync releases the held symbol on the next edge. The release gives a one-cycle strobe and leads to SPENT.
- R6: A stage claims at most one symbol per message. Further data symbols leave the holding register and outputs unchanged until a Sync re-arms the stage, and a chain drops data symbols beyond its length.
- R7: A stage in OPEN or SPENT gives no strobe and keeps out_data unchanged when a Sync arrives.
- R8: sym_half_sync alone never releases a held symbol. The symbol is still released on the following full Sync.
- R9: Cycles with sym_valid=0 are ignored for claiming and for Sync release.
- R10: In a chain, successive data symbols of a message land in successive stages, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_valid | input | 1 | A decoded symbol is present this cycle |
| sym_is_sync | input | 1 | The present symbol is a Sync |
| sym_half_sync | input | 1 | First half of a Sync recognised this cycle |
| sym_data | input | SYM_W | Decoded data symbol |
| catch_next | input | 1 | Permission from the upstream stage to claim |
| got_mine | output | 1 | Permission to the downstream stage |
| hold_q | output | SYM_W | Holding register contents |
| out_data | output | SYM_W | Output latch |
| out_stb | output | 1 | One-cycle strobe on each output latch update |

## Verification
The in-line assertions check, on every cycle:
- that got_mine is low under a Sync, a half-Sync or a low catch-next;
- that the holding register loads only on a claim and otherwise keeps its value;
- that every strobe lasts one cycle and carries the held symbol.

Some behaviours appear only across several stages and over a whole message, so only the bench scenarios can show them:
- the spreading of a message over the chain in arrival order;
- the dropping of symbols beyond the chain's length;
- the simultaneous release on the closing Sync;
- the silent re-arm of a stage that released early.

// File: rtl/symclaim_pkg.sv
package symclaim_pkg;
    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_HELD  = 2'd1,
        ST_SPENT = 2'd2
    } claim_state_e;
endpackage

// File: rtl/claim_fsm.sv
module claim_fsm
    import symclaim_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sym_valid,
    input  logic sym_is_sync,
    input  logic sym_half_sync,
    input  logic catch_next,
    output logic capture,
    output logic release_o,
    output logic got_mine
);
    claim_state_e state_q, state_d;
    logic sync_now, data_now;

    assign sync_now = sym_valid & sym_is_sync;
    assign data_now = sym_valid & ~sym_is_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:  if (data_now && catch_next) state_d = ST_HELD;
            ST_HELD: begin
                if (sync_now)                                state_d = ST_OPEN;
                else if (!catch_next && !sym_half_sync)      state_d = ST_SPENT;
            end
            ST_SPENT: if (sync_now) state_d = ST_OPEN;
            default:  state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        capture   = 1'b0;
        release_o = 1'b0;
        got_mine  = 1'b0;
        unique case (state_q)
            ST_OPEN:  capture = data_now && catch_next;
            ST_HELD: begin
                release_o = sync_now || (!catch_next && !sym_half_sync);
                got_mine  = catch_next && !sym_half_sync && !sync_now;
            end
            ST_SPENT: ;
            default: ;
        endcase
    end

    // R6: while holding, a data symbol never starts a second claim
    p_single_claim_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD) |-> !capture);
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    p_hold_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));
    p_hold_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/out_latch.sv
module out_latch #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         stb
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= '0;
            stb <= 1'b0;
        end else begin
            stb <= load;
            if (load) q <= d;
        end
    end

    p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);
endmodule

// File: rtl/symclaim_stage.sv
module symclaim_stage #(
    parameter int SYM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic             sym_is_sync,
    input  logic             sym_half_sync,
    input  logic [SYM_W-1:0] sym_data,
    input  logic             catch_next,
    output logic             got_mine,
    output logic [SYM_W-1:0] hold_q,
    output logic [SYM_W-1:0] out_data,
    output logic             out_stb
);
    logic capture, release_w;

    claim_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sym_valid    (sym_valid),
        .sym_is_sync  (sym_is_sync),
        .sym_half_sync(sym_half_sync),
        .catch_next   (catch_next),
        .capture      (capture),
        .release_o    (release_w),
        .got_mine     (got_mine)
    );

    hold_reg #(.W(SYM_W)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .load (capture),
        .d    (sym_data),
        .q    (hold_q)
    );

    out_latch #(.W(SYM_W)) u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .load (release_w),
        .d    (hold_q),
        .q    (out_data),
        .stb  (out_stb)
    );

    p_gm_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((sym_valid && sym_is_sync) || sym_half_sync || !catch_next) |-> !got_mine);
    p_stb_carries_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_stb |-> (out_data == hold_q));
    p_invalid_no_claim_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> $stable(hold_q));
endmodule

// File: tb/symclaim_stage_bench.sv
module symclaim_stage_bench;
    localparam int W = 10;
    localparam int N = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_valid = 1'b0, sym_is_sync = 1'b0, sym_half_sync = 1'b0;
    logic [W-1:0] sym_data = '0;
    logic head_catch = 1'b1;

    logic [N:0]   chain;
    logic [W-1:0] hq   [N];
    logic [W-1:0] od   [N];
    logic [N-1:0] stb;

    int checks = 0, failures = 0;

    typedef struct {
        logic [N-1:0] mask;
        logic [W-1:0] d0, d1, d2;
        string        tag;
    } exp_t;
    exp_t expq[$];

    always #2 clk = ~clk;

    assign chain[0] = head_catch;

    for (genvar i = 0; i < N; i++) begin : g_chain
        if (i == 0) begin : g_head
            symclaim_stage #(.SYM_W(W)) u_symclaim_stage (
                .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid),
                .sym_is_sync(sym_is_sync), .sym_half_sync(sym_half_sync),
                .sym_data(sym_data), .catch_next(chain[i]), .got_mine(chain[i+1]),
                .hold_q(hq[i]), .out_data(od[i]), .out_stb(stb[i]));
        end else begin : g_rest
            symclaim_stage #(.SYM_W(W)) u_stage (
                .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid),
                .sym_is_sync(sym_is_sync), .sym_half_sync(sym_half_sync),
                .sym_data(sym_data), .catch_next(chain[i]), .got_mine(chain[i+1]),
                .hold_q(hq[i]), .out_data(od[i]), .out_stb(stb[i]));
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic s, input logic h, input logic [W-1:0] d);
        @(negedge clk);
        sym_valid = v; sym_is_sync = s; sym_half_sync = h; sym_data = d;
        #1;
    endtask

    task automatic data(input logic [W-1:0] d); drive(1, 0, 0, d); endtask
    task automatic idle(); drive(0, 0, 0, '0); endtask

    task automatic expect_rel(input logic [N-1:0] m, input logic [W-1:0] a,
                              input logic [W-1:0] b, input logic [W-1:0] c, input string tag);
        exp_t e;
        e.mask = m; e.d0 = a; e.d1 = b; e.d2 = c; e.tag = tag;
        expq.push_back(e);
    endtask

    // monitor: registered outputs, sampled at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && stb != '0) begin
                if (expq.size() == 0) begin
                    check(0, "R7 unexpected strobe", 32'(stb), 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(stb == e.mask, {e.tag, " strobe mask"}, 32'(stb), 32'(e.mask));
                    if (e.mask[0]) check(od[0] == e.d0, {e.tag, " stage0 data"}, 32'(od[0]), 32'(e.d0));
                    if (e.mask[1]) check(od[1] == e.d1, {e.tag, " stage1 data"}, 32'(od[1]), 32'(e.d1));
                    if (e.mask[2]) check(od[2] == e.d2, {e.tag, " stage2 data"}, 32'(od[2]), 32'(e.d2));
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(chain[1] == 0 && chain[2] == 0 && chain[3] == 0, "R1 got_mine reset", 32'(chain), 1);
        check(stb == 0, "R1 strobe reset", 32'(stb), 0);
        check(od[0] == 0 && od[1] == 0 && od[2] == 0, "R1 out_data reset", 32'(od[0]), 0);
        rst_n = 1'b1;

        // R2 R10: three symbols spread over the chain, released on Sync (R4)
        data(10'h0A1);
        check(chain[1] == 0, "R2 got_mine not before capture", 32'(chain[1]), 0);
        data(10'h0B2);
        check(chain[1] == 1, "R2 got_mine after capture", 32'(chain[1]), 1);
        data(10'h0C3);
        idle();
        check(chain[3] == 1, "R10 last stage got_mine", 32'(chain[3]), 1);
        check(hq[0] == 10'h0A1 && hq[1] == 10'h0B2 && hq[2] == 10'h0C3, "R10 order", 32'(hq[2]), 32'h0C3);
        expect_rel(3'b111, 10'h0A1, 10'h0B2, 10'h0C3, "R4 sync release");
        drive(1, 1, 0, '0);
        check(chain[3:1] == 0, "R3 got_mine low on sync", 32'(chain[3:1]), 0);
        idle(); idle();

        // R9 R7: invalid cycles ignored, two-symbol message, stage2 silent
        drive(0, 0, 0, 10'h3FF);
        data(10'h011);
        drive(0, 1, 0, 10'h3EE);
        data(10'h022);
        idle();
        check(hq[2] == 10'h0C3, "R9 invalid ignored", 32'(hq[2]), 32'h0C3);
        expect_rel(3'b011, 10'h011, 10'h022, '0, "R7 partial message");
        drive(1, 1, 0, '0);
        idle(); idle();
        check(od[2] == 10'h0C3, "R7 silent stage unchanged", 32'(od[2]), 32'h0C3);

        // R6: overflow symbol dropped
        data(10'h101); data(10'h102); data(10'h103); data(10'h104);
        idle();
        check(hq[0] == 10'h101 && hq[2] == 10'h103, "R6 one claim each", 32'(hq[2]), 32'h103);
        expect_rel(3'b111, 10'h101, 10'h102, 10'h103, "R6 overflow");
        drive(1, 1, 0, '0);
        idle(); idle();

        // R8: half-Sync clears got_mine but does not release
        data(10'h201); data(10'h202); data(10'h203);
        drive(0, 0, 1, '0);
        check(chain[3:1] == 0, "R3 got_mine low on half sync", 32'(chain[3:1]), 0);
        expect_rel(3'b111, 10'h201, 10'h202, 10'h203, "R8 full sync after half");
        drive(1, 1, 0, '0);
        idle(); idle();

        // R5: catch-next drop releases the whole chain early
        data(10'h301); data(10'h302);
        expect_rel(3'b011, 10'h301, 10'h302, '0, "R5 drop release");
        @(negedge clk);
        sym_valid = 0; sym_is_sync = 0; sym_half_sync = 0; head_catch = 0;
        #1;
        check(chain[3:1] == 0, "R3 got_mine low when catch low", 32'(chain[3:1]), 0);
        @(negedge clk); head_catch = 1;
        // R6: spent head blocks further claims until Sync
        data(10'h3AA);
        idle();
        check(hq[2] == 10'h203, "R6 spent chain no claim", 32'(hq[2]), 32'h203);
        drive(1, 1, 0, '0);  // R7: re-arm with no strobe
        idle(); idle();

        // R10: chain usable again after re-arm
        data(10'h1E1); data(10'h1E2); data(10'h1E3);
        expect_rel(3'b111, 10'h1E1, 10'h1E2, 10'h1E3, "R10 after rearm");
        drive(1, 1, 0, '0);
        idle(); idle(); idle();

        check(expq.size() == 0, "R4 all expected releases seen", expq.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule